// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a virtual address into a physical address through a table of four segment descriptors. The upper bits of the virtual address pick a descriptor, and the lower bits are an offset into that segment. Each descriptor holds a physical start address, a size and a three-bit permission mask. The block checks the offset against the size and the access kind against the mask. When both checks pass, it returns start plus offset. When either check fails, it returns a fault code.

A requester presents a request for one cycle. The physical address and the fault code come back registered in the next cycle, marked by `resp_valid`. A two-state machine tracks whether a response is on the outputs. In `ST_QUIET` nothing is presented. In `ST_PRESENT` a response is on the outputs. Any cycle with `req_valid` moves the machine to `ST_PRESENT`, either from `ST_QUIET` or by staying in `ST_PRESENT`. A cycle without a request moves it to `ST_QUIET`, or keeps it there.

Kernel software loads and saves the descriptors through a configuration port. Readback of that port is combinational. A write is accepted only while `priv_kernel` is high. A write attempted in user mode changes nothing and raises a one-cycle violation flag.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is `req_vaddr[13:12]` and the offset is `req_vaddr[11:0]`.
- R2: When the offset is below the segment size and the access is permitted, `resp_paddr` is (start + offset) modulo 2^16 and `resp_fault` is 0.
- R3: When the offset is greater than or equal to the segment size, `resp_fault` is 1 (limit) and `resp_paddr` is 0.
- R4: Access codes are 0 for read, 1 for write and 2 for execute. Code n needs rights bit n (bit 0 read, bit 1 write, bit 2 execute). Code 3 is never permitted. A refused access gives `resp_fault` 2 (rights) and `resp_paddr` 0.
- R5: When the limit check and the rights check both fail, `resp_fault` is 1.
- R6: `resp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. While `resp_valid` is low, `resp_paddr` and `resp_fault` are 0.
- R7: After reset the descriptors are as follows. Segment 0 has start 0x4000, size 0x700 and rights 3'b101. Segment 1 has start 0, size 0x500 and rights 3'b011. Segment 2 has start 0, size 0 and rights 3'b000. Segment 3 has start 0x2000, size 0x1000 and rights 3'b011.
- R8: A `cfg_we` with `priv_kernel` high replaces descriptor `cfg_sel` at the clock edge. Readback and requests in later cycles see the new contents. A request in the same cycle as the write uses the old contents.
- R9: A `cfg_we` with `priv_kernel` low leaves the table unchanged, and `priv_viol` is high in the following cycle only.
- R10: `cfg_rd_start`, `cfg_rd_size` and `cfg_rd_rights` show descriptor `cfg_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| priv_kernel | input | 1 | 1 = privileged mode |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 14 | Virtual address |
| req_acc | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| resp_valid | output | 1 | Response present |
| resp_paddr | output | 16 | Physical address, 0 on fault |
| resp_fault | output | 2 | 0 none, 1 limit, 2 rights |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Descriptor index for write and readback |
| cfg_start | input | 16 | Start address to write |
| cfg_size | input | 13 | Size to write |
| cfg_rights | input | 3 | Rights mask to write |
| cfg_rd_start | output | 16 | Start of selected descriptor |
| cfg_rd_size | output | 13 | Size of selected descriptor |
| cfg_rd_rights | output | 3 | Rights of selected descriptor |
| priv_viol | output | 1 | A user-mode write was refused last cycle |

## Verification
The bench drives offsets at exactly size-1 and exactly size, including the last offset of a full 0x1000 segment and any access to a size-0 segment. An off-by-one comparison would pass or fault the wrong one of these accesses. It sends accesses that break both rules at once, so a design that checks the two rules in the wrong order reports a rights fault where a limit fault is expected. It sends the reserved access code, and a design that indexes the mask with that code would let the access through. The bench also writes the same descriptor it is translating through in the same cycle, and tries user-mode writes that are followed by readback and translation. A design with a write-through path, or with a privilege gate that leaks, shows the new values where the old ones are expected.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_LIMIT  = 2'd1,
        FLT_RIGHTS = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic {
        ST_QUIET   = 1'b0,
        ST_PRESENT = 1'b1
    } resp_state_e;

    localparam int RIGHTS_BITS = 3;

endpackage

// File: rtl/seg_desc_table.sv
`timescale 1ns/1ps
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int SEG_BITS  = 2,
    parameter int PA_BITS   = 16,
    parameter int SIZE_BITS = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEG_BITS-1:0]    wr_sel,
    input  logic [PA_BITS-1:0]     wr_start,
    input  logic [SIZE_BITS-1:0]   wr_size,
    input  logic [RIGHTS_BITS-1:0] wr_rights,
    input  logic [SEG_BITS-1:0]    lk_sel,
    output logic [PA_BITS-1:0]     lk_start,
    output logic [SIZE_BITS-1:0]   lk_size,
    output logic [RIGHTS_BITS-1:0] lk_rights,
    input  logic [SEG_BITS-1:0]    rb_sel,
    output logic [PA_BITS-1:0]     rb_start,
    output logic [SIZE_BITS-1:0]   rb_size,
    output logic [RIGHTS_BITS-1:0] rb_rights
);

    localparam int NSEG = 1 << SEG_BITS;

    function automatic logic [PA_BITS-1:0] init_start(input int idx);
        case (idx)
            0:       return PA_BITS'(16'h4000);
            3:       return PA_BITS'(16'h2000);
            default: return '0;
        endcase
    endfunction

    function automatic logic [SIZE_BITS-1:0] init_size(input int idx);
        case (idx)
            0:       return SIZE_BITS'(13'h0700);
            1:       return SIZE_BITS'(13'h0500);
            3:       return SIZE_BITS'(13'h1000);
            default: return '0;
        endcase
    endfunction

    function automatic logic [RIGHTS_BITS-1:0] init_rights(input int idx);
        case (idx)
            0:       return 3'b101;
            1:       return 3'b011;
            3:       return 3'b011;
            default: return 3'b000;
        endcase
    endfunction

    logic [PA_BITS-1:0]     start_q  [NSEG];
    logic [SIZE_BITS-1:0]   size_q   [NSEG];
    logic [RIGHTS_BITS-1:0] rights_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_q[g]  <= init_start(g);
                size_q[g]   <= init_size(g);
                rights_q[g] <= init_rights(g);
            end else if (wr_en && wr_sel == SEG_BITS'(g)) begin
                start_q[g]  <= wr_start;
                size_q[g]   <= wr_size;
                rights_q[g] <= wr_rights;
            end
        end
    end

    always_comb begin
        lk_start  = start_q[lk_sel];
        lk_size   = size_q[lk_sel];
        lk_rights = rights_q[lk_sel];
        rb_start  = start_q[rb_sel];
        rb_size   = size_q[rb_sel];
        rb_rights = rights_q[rb_sel];
    end

endmodule

// File: rtl/seg_check.sv
`timescale 1ns/1ps
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_BITS  = 12,
    parameter int PA_BITS   = 16,
    parameter int SIZE_BITS = 13
) (
    input  logic [OFF_BITS-1:0]    offset,
    input  logic [1:0]             acc,
    input  logic [PA_BITS-1:0]     seg_start,
    input  logic [SIZE_BITS-1:0]   seg_size,
    input  logic [RIGHTS_BITS-1:0] seg_rights,
    output logic [PA_BITS-1:0]     paddr,
    output fault_e                 fault
);

    logic over_limit;
    logic allowed;

    always_comb begin
        over_limit = (SIZE_BITS'(offset) >= seg_size);
        unique case (acc_e'(acc))
            ACC_READ:  allowed = seg_rights[0];
            ACC_WRITE: allowed = seg_rights[1];
            ACC_EXEC:  allowed = seg_rights[2];
            default:   allowed = 1'b0;
        endcase

        if (over_limit) begin
            fault = FLT_LIMIT;
            paddr = '0;
        end else if (!allowed) begin
            fault = FLT_RIGHTS;
            paddr = '0;
        end else begin
            fault = FLT_NONE;
            paddr = seg_start + PA_BITS'(offset);
        end
    end

endmodule

// File: rtl/seg_xlate.sv
`timescale 1ns/1ps
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_BITS = 2,
    parameter int OFF_BITS = 12,
    parameter int PA_BITS  = 16,
    localparam int VA_BITS   = SEG_BITS + OFF_BITS,
    localparam int SIZE_BITS = OFF_BITS + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   priv_kernel,
    input  logic                   req_valid,
    input  logic [VA_BITS-1:0]     req_vaddr,
    input  logic [1:0]             req_acc,
    output logic                   resp_valid,
    output logic [PA_BITS-1:0]     resp_paddr,
    output logic [1:0]             resp_fault,
    input  logic                   cfg_we,
    input  logic [SEG_BITS-1:0]    cfg_sel,
    input  logic [PA_BITS-1:0]     cfg_start,
    input  logic [SIZE_BITS-1:0]   cfg_size,
    input  logic [RIGHTS_BITS-1:0] cfg_rights,
    output logic [PA_BITS-1:0]     cfg_rd_start,
    output logic [SIZE_BITS-1:0]   cfg_rd_size,
    output logic [RIGHTS_BITS-1:0] cfg_rd_rights,
    output logic                   priv_viol
);

    resp_state_e state_q, state_d;

    logic [SEG_BITS-1:0]    seg_idx;
    logic [OFF_BITS-1:0]    seg_off;
    logic [PA_BITS-1:0]     lk_start;
    logic [SIZE_BITS-1:0]   lk_size;
    logic [RIGHTS_BITS-1:0] lk_rights;
    logic [PA_BITS-1:0]     xl_paddr;
    fault_e                 xl_fault;
    logic                   wr_ok;

    assign seg_idx = req_vaddr[VA_BITS-1:OFF_BITS];
    assign seg_off = req_vaddr[OFF_BITS-1:0];
    assign wr_ok   = cfg_we && priv_kernel;

    seg_desc_table #(
        .SEG_BITS (SEG_BITS),
        .PA_BITS  (PA_BITS),
        .SIZE_BITS(SIZE_BITS)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_sel   (cfg_sel),
        .wr_start (cfg_start),
        .wr_size  (cfg_size),
        .wr_rights(cfg_rights),
        .lk_sel   (seg_idx),
        .lk_start (lk_start),
        .lk_size  (lk_size),
        .lk_rights(lk_rights),
        .rb_sel   (cfg_sel),
        .rb_start (cfg_rd_start),
        .rb_size  (cfg_rd_size),
        .rb_rights(cfg_rd_rights)
    );

    seg_check #(
        .OFF_BITS (OFF_BITS),
        .PA_BITS  (PA_BITS),
        .SIZE_BITS(SIZE_BITS)
    ) check_i (
        .offset    (seg_off),
        .acc       (req_acc),
        .seg_start (lk_start),
        .seg_size  (lk_size),
        .seg_rights(lk_rights),
        .paddr     (xl_paddr),
        .fault     (xl_fault)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (req_valid) state_d = ST_PRESENT;
            ST_PRESENT: if (!req_valid) state_d = ST_QUIET;
            default:    state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_paddr <= '0;
            resp_fault <= FLT_NONE;
            priv_viol  <= 1'b0;
        end else begin
            priv_viol <= cfg_we && !priv_kernel;
            if (req_valid) begin
                resp_paddr <= xl_paddr;
                resp_fault <= xl_fault;
            end else begin
                resp_paddr <= '0;
                resp_fault <= FLT_NONE;
            end
        end
    end

    assign resp_valid = (state_q == ST_PRESENT);

endmodule

// File: rtl/seg_xlate_chk.sv
`timescale 1ns/1ps
module seg_xlate_chk #(
    parameter int PA_BITS = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               priv_kernel,
    input logic               req_valid,
    input logic               cfg_we,
    input logic               resp_valid,
    input logic [PA_BITS-1:0] resp_paddr,
    input logic [1:0]         resp_fault,
    input logic               priv_viol
);

    p_resp_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    p_no_spurious_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    p_quiet_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (resp_paddr == '0 && resp_fault == 2'd0));

    p_fault_zero_pa_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 2'd0) |-> resp_paddr == '0);

    p_fault_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault != 2'd3);

    p_user_write_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !priv_kernel) |=> priv_viol);

    p_flag_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol |-> $past(cfg_we && !priv_kernel));

endmodule

bind seg_xlate seg_xlate_chk #(.PA_BITS(PA_BITS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .priv_kernel(priv_kernel),
    .req_valid  (req_valid),
    .cfg_we     (cfg_we),
    .resp_valid (resp_valid),
    .resp_paddr (resp_paddr),
    .resp_fault (resp_fault),
    .priv_viol  (priv_viol)
);

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_kernel = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        resp_valid;
    logic [15:0] resp_paddr;
    logic [1:0]  resp_fault;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_start = '0;
    logic [12:0] cfg_size = '0;
    logic [2:0]  cfg_rights = '0;
    logic [15:0] cfg_rd_start;
    logic [12:0] cfg_rd_size;
    logic [2:0]  cfg_rd_rights;
    logic        priv_viol;

    always #2 clk = ~clk;

    seg_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .priv_kernel(priv_kernel),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_start(cfg_start),
        .cfg_size(cfg_size), .cfg_rights(cfg_rights),
        .cfg_rd_start(cfg_rd_start), .cfg_rd_size(cfg_rd_size),
        .cfg_rd_rights(cfg_rd_rights), .priv_viol(priv_viol)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // reference model state
    int m_start [4];
    int m_size  [4];
    int m_rights[4];
    int e_valid = 0, e_pa = 0, e_fault = 0, e_viol = 0;
    string e_tag = "R6 reset";

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_start  = '{'h4000, 0, 0, 'h2000};
        m_size   = '{'h700, 'h500, 0, 'h1000};
        m_rights = '{5, 3, 0, 3};
    endtask

    // one clock of stimulus: checks previous response, drives, predicts
    task automatic step(input bit pk, input bit rv, input int va, input int acc,
                        input bit we, input int sel, input int st, input int sz,
                        input int rt, input string tag);
        int seg, off;
        @(negedge clk);
        check(e_tag, "resp_valid", int'(resp_valid), e_valid);
        check(e_tag, "resp_paddr", int'(resp_paddr), e_pa);
        check(e_tag, "resp_fault", int'(resp_fault), e_fault);
        check("R9", "priv_viol", int'(priv_viol), e_viol);
        priv_kernel = pk; req_valid = rv; req_vaddr = 14'(va); req_acc = 2'(acc);
        cfg_we = we; cfg_sel = 2'(sel); cfg_start = 16'(st);
        cfg_size = 13'(sz); cfg_rights = 3'(rt);
        #1;
        check("R10", "cfg_rd_start", int'(cfg_rd_start), m_start[sel]);
        check("R10", "cfg_rd_size", int'(cfg_rd_size), m_size[sel]);
        check("R10", "cfg_rd_rights", int'(cfg_rd_rights), m_rights[sel]);
        e_tag = tag;
        e_viol = (we && !pk) ? 1 : 0;
        e_valid = rv ? 1 : 0;
        e_pa = 0;
        e_fault = 0;
        if (rv) begin
            seg = (va >> 12) & 3;
            off = va & 'hfff;
            if (off >= m_size[seg]) e_fault = 1;
            else if (acc == 3 || ((m_rights[seg] >> acc) & 1) == 0) e_fault = 2;
            else e_pa = (m_start[seg] + off) & 'hffff;
        end
        if (we && pk) begin
            m_start[sel]  = st & 'hffff;
            m_size[sel]   = sz & 'h1fff;
            m_rights[sel] = rt & 7;
        end
    endtask

    task automatic req(input int va, input int acc, input string tag);
        step(1'b0, 1'b1, va, acc, 1'b0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R6 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R7 reset contents via readback before any write
        for (int s = 0; s < 4; s++) begin
            cfg_sel = 2'(s);
            #0.5;
            check("R7", "reset start", int'(cfg_rd_start), m_start[s]);
            check("R7", "reset size", int'(cfg_rd_size), m_size[s]);
            check("R7", "reset rights", int'(cfg_rd_rights), m_rights[s]);
        end
        check("R6", "reset resp_valid", int'(resp_valid), 0);
        rst_n = 1'b1;

        req('h0010, 2, "R2 seg0 exec");
        req('h3fff, 0, "R2 R1 seg3 last offset");
        req('h06ff, 2, "R3 seg0 size-1");
        req('h0700, 2, "R3 seg0 at size");
        req('h2000, 0, "R3 seg2 empty");
        req('h0004, 1, "R4 seg0 write refused");
        req('h1004, 3, "R4 reserved code");
        req('h1123, 1, "R2 R1 seg1 write");
        req('h0800, 1, "R5 limit before rights");
        step(1'b0, 1'b0, 0, 0, 1'b0, 0, 0, 0, 0, "R6 idle");
        step(1'b0, 1'b0, 0, 0, 1'b0, 0, 0, 0, 0, "R6 idle again");
        // R8 kernel write with same-cycle lookup on old contents
        step(1'b1, 1'b1, 'h2000, 0, 1'b1, 2, 'h8000, 'h10, 7, "R8 old contents");
        req('h200f, 1, "R8 new seg2 in range");
        req('h2010, 1, "R8 new seg2 at size");
        // R9 user write refused
        step(1'b0, 1'b1, 'h1000, 0, 1'b1, 1, 'h1234, 'h1fff, 7, "R9 during user write");
        req('h1000, 0, "R9 seg1 unchanged");
        req('h1000, 2, "R9 seg1 rights unchanged");
        // randomized traffic, model compared every clock
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom), 1'(($urandom % 4) != 0), int'($urandom % 'h4000),
                 int'($urandom % 4), 1'(($urandom % 8) == 0), int'($urandom % 4),
                 int'($urandom % 'h10000), int'($urandom % 'h1400),
                 int'($urandom % 8), "R1 R2 R3 R4 R5 R8 R9 random");
        end
        step(1'b0, 1'b0, 0, 0, 1'b0, 0, 0, 0, 0, "R6 drain");
        @(negedge clk);
        check(e_tag, "resp_valid", int'(resp_valid), e_valid);
        check(e_tag, "resp_paddr", int'(resp_paddr), e_pa);
        check(e_tag, "resp_fault", int'(resp_fault), e_fault);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule